// File: doc/BRIEF.md
# Bus-Matching Endian Read Port

This block sits between the read side of a 36-bit FIFO and a consumer whose bus may be narrower. It shows each stored long word on the output bus in one of three widths. In full width the whole word moves in a single read. In half width the word leaves as two 18-bit pieces. In byte width it leaves as four 9-bit pieces. For the two narrow widths the pieces can come out most-significant first (big-endian) or least-significant first (little-endian).

The width and the piece order are set by three configuration pins. Their values are captured while master reset is held and stay frozen once master reset is released. A separate partial reset clears the output register and the piece position, and keeps the captured configuration.

The FIFO head word is presented on `fifo_word`, and `fifo_avail` is high while that word is valid. A consumer read loads the next piece into the output register. The block pulses `fifo_pop` only on the read that delivers the last piece of the head word, so no word is dropped before it has been fully delivered.

Top module: `bm_read_port`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `rd_data` is cleared to zero and the piece position returns to the first piece. The configuration pins sampled on the last clock edge with `rst_n` low take effect.
- R2: With `cfg_narrow` low the bus is full width. Each qualified read (`rd_en` and `fifo_avail` both high at a rising edge) loads all 36 bits of `fifo_word` into `rd_data` and pulses `fifo_pop`. `cfg_big_end` has no effect in this mode.
- R3: With `cfg_narrow` high, `cfg_byte` low and `cfg_big_end` high, the two reads of a word deliver bits 35..18 and then bits 17..0.
- R4: With `cfg_narrow` high, `cfg_byte` low and `cfg_big_end` low, the two reads of a word deliver bits 17..0 and then bits 35..18.
- R5: With `cfg_narrow` high, `cfg_byte` high and `cfg_big_end` high, the four reads of a word deliver bits 35..27, 26..18, 17..9 and then 8..0.
- R6: With `cfg_narrow` high, `cfg_byte` high and `cfg_big_end` low, the four reads of a word deliver bits 8..0, 17..9, 26..18 and then 35..27.
- R7: In half width, `rd_data[35:18]` is always zero. In byte width, `rd_data[35:9]` is always zero.
- R8: Changes on `cfg_narrow`, `cfg_byte` and `cfg_big_end` while `rst_n` is high have no effect on width or order.
- R9: While `prst_n` is low (synchronous, active low), `rd_data` is cleared to zero and the next read delivers the first piece of the head word. The captured width and order are kept.
- R10: A rising edge without a qualified read leaves `rd_data` and the piece position unchanged, and `fifo_pop` stays low.
- R11: `fifo_pop` is combinational. It is high only during a qualified read of the last piece of the head word: every read in full width, the second read in half width, the fourth read in byte width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Master reset, synchronous, active low; captures configuration |
| prst_n | input | 1 | Partial reset, synchronous, active low; keeps configuration |
| cfg_narrow | input | 1 | High selects a narrow bus (half or byte), low selects full width |
| cfg_byte | input | 1 | With cfg_narrow high: high selects byte width, low selects half width |
| cfg_big_end | input | 1 | High delivers the most significant piece first |
| fifo_word | input | 36 | Head word of the FIFO |
| fifo_avail | input | 1 | Head word is valid |
| fifo_pop | output | 1 | Removes the head word from the FIFO |
| rd_en | input | 1 | Consumer read request |
| rd_data | output | 36 | Output register, zero-extended in the narrow widths |

## Verification
The bench runs all five width/order combinations against one word with distinct fields. If the lane mapping were reversed or shifted, a wrong slice would appear on a specific read.

It inserts idle edges with `fifo_avail` low in the middle of a word. A counter that advanced on unqualified requests would skip a piece or pop early.

It changes the configuration pins after reset release. A design that did not freeze them would switch width in the middle of a run.

It applies a partial reset in the middle of a word. The bench then expects a zero output, then the first piece again, and still the byte little-endian order. A design that cleared the configuration, or kept the piece position, would deliver a different slice.

// File: rtl/bm_pkg.sv
package bm_pkg;

    // Number of bits needed to index the largest piece count (four bytes).
    localparam int PIECE_IDX_W = 2;

    typedef enum logic [1:0] {
        BUS_FULL = 2'd0,
        BUS_HALF = 2'd1,
        BUS_BYTE = 2'd2
    } bus_mode_e;

    typedef struct packed {
        bus_mode_e mode;
        logic      big_end;
    } port_cfg_t;

    // Index of the final piece of a word for a given bus mode.
    function automatic logic [PIECE_IDX_W-1:0] last_piece(bus_mode_e m);
        case (m)
            BUS_HALF: last_piece = PIECE_IDX_W'(1);
            BUS_BYTE: last_piece = PIECE_IDX_W'(3);
            default:  last_piece = '0;
        endcase
    endfunction

endpackage

// File: rtl/bmrp_cfg_latch.sv
module bmrp_cfg_latch
    import bm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_narrow,
    input  logic      cfg_byte,
    input  logic      cfg_big_end,
    output port_cfg_t cfg_q
);

    port_cfg_t cfg_d;
    port_cfg_t cfg_r_q;

    always_comb begin
        cfg_d = cfg_r_q;
        if (!rst_n) begin
            if (!cfg_narrow) begin
                cfg_d.mode = BUS_FULL;
            end else if (cfg_byte) begin
                cfg_d.mode = BUS_BYTE;
            end else begin
                cfg_d.mode = BUS_HALF;
            end
            cfg_d.big_end = cfg_big_end;
        end
    end

    always_ff @(posedge clk) begin
        cfg_r_q <= cfg_d;
    end

    assign cfg_q = cfg_r_q;

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(cfg_r_q));

endmodule

// File: rtl/bmrp_piece_seq.sv
module bmrp_piece_seq
    import bm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   prst_n,
    input  logic                   rd_fire,
    input  bus_mode_e              mode,
    output logic [PIECE_IDX_W-1:0] piece_idx,
    output logic                   piece_last
);

    typedef struct packed {
        logic [PIECE_IDX_W-1:0] idx;
    } seq_state_t;

    seq_state_t st_d;
    seq_state_t st_q;
    logic [PIECE_IDX_W-1:0] last_idx;

    assign last_idx   = last_piece(mode);
    assign piece_idx  = st_q.idx;
    assign piece_last = (st_q.idx == last_idx);

    always_comb begin
        st_d = st_q;
        if (!rst_n || !prst_n) begin
            st_d.idx = '0;
        end else if (rd_fire) begin
            if (piece_last) begin
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + PIECE_IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R11
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
        1'b1 |=> (st_q.idx <= last_idx));

    // R10
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
        !rd_fire |=> $stable(st_q.idx));

endmodule

// File: rtl/bmrp_lane_sel.sv
module bmrp_lane_sel
    import bm_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic [WORD_W-1:0]      word,
    input  port_cfg_t              cfg,
    input  logic [PIECE_IDX_W-1:0] piece_idx,
    output logic [WORD_W-1:0]      piece
);

    localparam int HALF_W  = WORD_W / 2;
    localparam int BYTE_W  = WORD_W / 4;
    localparam int N_HALF  = 2;
    localparam int N_BYTE  = 4;

    logic [HALF_W-1:0] half_lane [N_HALF];
    logic [BYTE_W-1:0] byte_lane [N_BYTE];
    logic [PIECE_IDX_W-1:0] lane;

    // Lane 0 is always the least significant slice of the word.
    for (genvar g = 0; g < N_HALF; g++) begin : g_half
        assign half_lane[g] = word[g*HALF_W +: HALF_W];
    end

    for (genvar g = 0; g < N_BYTE; g++) begin : g_byte
        assign byte_lane[g] = word[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        lane  = '0;
        piece = '0;
        case (cfg.mode)
            BUS_HALF: begin
                lane = cfg.big_end ? {1'b0, ~piece_idx[0]} : {1'b0, piece_idx[0]};
                piece[HALF_W-1:0] = half_lane[lane[0]];
            end
            BUS_BYTE: begin
                lane = cfg.big_end ? (PIECE_IDX_W'(N_BYTE - 1) - piece_idx) : piece_idx;
                piece[BYTE_W-1:0] = byte_lane[lane];
            end
            default: begin
                piece = word;
            end
        endcase
    end

endmodule

// File: rtl/bm_read_port.sv
module bm_read_port
    import bm_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              cfg_narrow,
    input  logic              cfg_byte,
    input  logic              cfg_big_end,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic              fifo_avail,
    output logic              fifo_pop,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data
);

    localparam int HALF_W = WORD_W / 2;
    localparam int BYTE_W = WORD_W / 4;

    typedef struct packed {
        logic [WORD_W-1:0] data;
    } out_state_t;

    port_cfg_t              cfg_q;
    logic                   rd_fire;
    logic [PIECE_IDX_W-1:0] piece_idx;
    logic                   piece_last;
    logic [WORD_W-1:0]      piece;
    out_state_t             out_d;
    out_state_t             out_q;

    assign rd_fire = rd_en && fifo_avail;

    bmrp_cfg_latch u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_narrow  (cfg_narrow),
        .cfg_byte    (cfg_byte),
        .cfg_big_end (cfg_big_end),
        .cfg_q       (cfg_q)
    );

    bmrp_piece_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .prst_n     (prst_n),
        .rd_fire    (rd_fire),
        .mode       (cfg_q.mode),
        .piece_idx  (piece_idx),
        .piece_last (piece_last)
    );

    bmrp_lane_sel #(.WORD_W(WORD_W)) u_sel (
        .word      (fifo_word),
        .cfg       (cfg_q),
        .piece_idx (piece_idx),
        .piece     (piece)
    );

    assign fifo_pop = rd_fire && piece_last && rst_n && prst_n;

    always_comb begin
        out_d = out_q;
        if (!rst_n || !prst_n) begin
            out_d.data = '0;
        end else if (rd_fire) begin
            out_d.data = piece;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign rd_data = out_q.data;

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
        !rd_fire |=> $stable(rd_data));

    // R7
    half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == BUS_HALF) |-> (rd_data[WORD_W-1:HALF_W] == '0));

    // R7
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == BUS_BYTE) |-> (rd_data[WORD_W-1:BYTE_W] == '0));

    // R11
    pop_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
        fifo_pop |=> (piece_idx == '0));

    // R2
    full_pop_chk: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
        (cfg_q.mode == BUS_FULL && rd_fire) |-> fifo_pop);

endmodule

// File: tb/bm_read_port_tb_top.sv
module bm_read_port_tb_top;

    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         prst_n = 1'b1;
    logic         cfg_narrow = 1'b0;
    logic         cfg_byte = 1'b0;
    logic         cfg_big_end = 1'b0;
    logic [W-1:0] fifo_word = '0;
    logic         fifo_avail = 1'b0;
    logic         fifo_pop;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_data;

    always #10 clk = ~clk;

    bm_read_port #(.WORD_W(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .prst_n      (prst_n),
        .cfg_narrow  (cfg_narrow),
        .cfg_byte    (cfg_byte),
        .cfg_big_end (cfg_big_end),
        .fifo_word   (fifo_word),
        .fifo_avail  (fifo_avail),
        .fifo_pop    (fifo_pop),
        .rd_en       (rd_en),
        .rd_data     (rd_data)
    );

    typedef struct {
        logic [W-1:0] data;
        string        tag;
    } exp_t;

    exp_t sbq[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   mon_fire;

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected slice: lane 0 is least significant; big-endian starts at the top lane.
    function automatic logic [W-1:0] exp_piece(logic [W-1:0] w, int n, bit big, int k);
        int lane;
        int pw;
        logic [W-1:0] mask;
        pw   = W / n;
        lane = big ? (n - 1 - k) : k;
        mask = (W'(1) << pw) - W'(1);
        return (w >> (lane * pw)) & mask;
    endfunction

    // Monitor: after each qualified edge, compare the output with the oldest expectation.
    always @(posedge clk) begin
        mon_fire = rd_en && fifo_avail && rst_n && prst_n;
        #5;
        if (mon_fire) begin
            if (sbq.size() == 0) begin
                n_vec++;
                n_bad++;
                $display("FAIL monitor: actual %h expected none", rd_data);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(e.tag, rd_data, e.data);
            end
        end
    end

    task automatic do_reset(bit narrow, bit bsel, bit big);
        @(negedge clk);
        rd_en = 1'b0;
        fifo_avail = 1'b0;
        rst_n = 1'b0;
        cfg_narrow = narrow;
        cfg_byte = bsel;
        cfg_big_end = big;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset output", rd_data, '0);
    endtask

    task automatic rd(logic [W-1:0] w, logic [W-1:0] exp, bit exp_pop, string tag);
        exp_t e;
        @(negedge clk);
        fifo_word = w;
        fifo_avail = 1'b1;
        rd_en = 1'b1;
        #1;
        check({tag, " R11 pop"}, W'(fifo_pop), W'(exp_pop));
        e.data = exp;
        e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        rd_en = 1'b0;
        fifo_avail = 1'b0;
    endtask

    task automatic rd_word(logic [W-1:0] w, int n, bit big, string tag);
        for (int k = 0; k < n; k++) begin
            rd(w, exp_piece(w, n, big, k), (k == n - 1), tag);
        end
    endtask

    task automatic idle_edge(string tag);
        logic [W-1:0] held;
        @(negedge clk);
        held = rd_data;
        rd_en = 1'b1;
        fifo_avail = 1'b0;
        #1;
        check({tag, " R10 pop low"}, W'(fifo_pop), '0);
        @(negedge clk);
        check({tag, " R10 hold"}, rd_data, held);
        rd_en = 1'b0;
    endtask

    localparam logic [W-1:0] WA = 36'hA_BCDE_F012;
    localparam logic [W-1:0] WB = 36'h5_1372_9C4E;

    initial begin
        // R1, R2: full width, endian ignored
        do_reset(1'b0, 1'b0, 1'b1);
        rd_word(WA, 1, 1'b0, "R2 full");
        // R8: configuration pins moved after release have no effect
        @(negedge clk);
        cfg_narrow = 1'b1;
        cfg_byte = 1'b1;
        cfg_big_end = 1'b0;
        rd_word(WB, 1, 1'b0, "R8 frozen full");

        // R3 with an idle edge mid-word (R10)
        do_reset(1'b1, 1'b0, 1'b1);
        rd(WA, exp_piece(WA, 2, 1'b1, 0), 1'b0, "R3 half big");
        idle_edge("R3");
        rd(WA, exp_piece(WA, 2, 1'b1, 1), 1'b1, "R3 half big");
        @(negedge clk);
        check("R7 half upper zero", W'(rd_data[W-1:18]), '0);

        // R4
        do_reset(1'b1, 1'b0, 1'b0);
        rd_word(WA, 2, 1'b0, "R4 half little");
        rd_word(WB, 2, 1'b0, "R4 half little");

        // R5
        do_reset(1'b1, 1'b1, 1'b1);
        rd_word(WA, 4, 1'b1, "R5 byte big");
        rd(WB, exp_piece(WB, 4, 1'b1, 0), 1'b0, "R5 byte big");
        idle_edge("R5");
        rd(WB, exp_piece(WB, 4, 1'b1, 1), 1'b0, "R5 byte big");
        rd(WB, exp_piece(WB, 4, 1'b1, 2), 1'b0, "R5 byte big");
        rd(WB, exp_piece(WB, 4, 1'b1, 3), 1'b1, "R5 byte big");
        @(negedge clk);
        check("R7 byte upper zero", W'(rd_data[W-1:9]), '0);

        // R6, then R9 partial reset mid-word
        do_reset(1'b1, 1'b1, 1'b0);
        rd_word(WA, 4, 1'b0, "R6 byte little");
        rd(WB, exp_piece(WB, 4, 1'b0, 0), 1'b0, "R6 byte little");
        rd(WB, exp_piece(WB, 4, 1'b0, 1), 1'b0, "R6 byte little");
        @(negedge clk);
        prst_n = 1'b0;
        @(negedge clk);
        prst_n = 1'b1;
        #1;
        check("R9 partial reset output", rd_data, '0);
        rd_word(WB, 4, 1'b0, "R9 restart keeps byte little");

        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule